// File: doc/BRIEF.md
# SAR Conversion Sequencer with Abort

This block is the digital control sequencer of a successive-approximation converter. A falling edge on the start strobe, seen while the active-low select is low, begins a conversion. The block then drives a bit-trial search from the most significant bit down to the least significant bit, one trial per clock. In each trial it reads the comparator decision for the current trial code. At the end it latches the decided code into a parallel result register.

Both control inputs are registered in the system clock domain. Edges are found by comparing each registered value with its previous sample.

Two behaviours set this block apart from a plain sequencer:

- **Trim-load conversions.** After power-up reset, the first three conversions that finish are reserved for loading trim data. They never raise the data-valid flag.
- **Abort.** A start edge or a select edge that arrives while a conversion is running aborts it. The abort is a single-clock, self-clearing reset. It zeroes the result, drops BUSY and returns the sequencer to sampling. It does not count as a trim-load conversion.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst_n` is low and right after it is released, `busy` is 0, `result` is all zeros and `result_valid` is 0.
- R2: With the sequencer idle and `sel_n` low, driving `start_n` from 1 to 0 makes `busy` read 1 after the second rising clock edge that follows the change. One edge is for sampling and one is for the sequencer.
- R3: A falling edge on `start_n` while `sel_n` is high and the sequencer is idle starts no conversion. `busy` stays 0.
- R4: A conversion that is not aborted keeps `busy` high for exactly WIDTH clock cycles. In the k-th busy cycle (k counted from 0), `cmp_bit` decides bit WIDTH-1-k of the code. A 1 keeps the bit and a 0 clears it.
- R5: When `busy` falls at the normal end of a conversion, `result` holds the decided code. It keeps that value while the sequencer stays idle.
- R6: `result_valid` is high for exactly one cycle, which is the cycle in which `busy` falls at a normal end. It rises only if TRIM_CONVS (3) normal conversions have already finished since reset, so the first three completions report 0.
- R7: A falling edge on `start_n` while `sel_n` is low during a conversion aborts it. In the next cycle, `busy` is 0, `result` is all zeros and `result_valid` is 0.
- R8: A falling edge on `sel_n` during a conversion aborts it in the same way. A rising edge on `sel_n` has no effect.
- R9: Aborted conversions do not advance the count of trim-load conversions. Asserting `rst_n` clears that count, so three invalid completions follow again.
- R10: After an abort the sequencer is idle. The next qualified start edge runs a full normal conversion.
- R11: A falling edge on `start_n` while `sel_n` is high during a conversion is ignored. The conversion finishes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| sel_n | input | 1 | Active-low device select |
| start_n | input | 1 | Conversion start strobe; its falling edge is the event |
| cmp_bit | input | 1 | Comparator decision for the current trial code; 1 keeps the trial bit |
| busy | output | 1 | High while a conversion is in progress |
| result | output | WIDTH | Latched conversion code; zero after reset or abort |
| result_valid | output | 1 | One-cycle data-valid pulse at the normal end of a post-trim conversion |

## Verification
The bench builds the block with the defaults: WIDTH of 16 and TRIM_CONVS of 3.

At 16 bits, the all-ones, all-zeros and alternating patterns drive both comparator outcomes through every trial position. The short trial chain makes it possible to abort at an early step and at a late step, by either control input. With three trim-load conversions, an abort can be placed between the second and third completion. A second reset replays the trim window, which shows that only normal completions move the counter and that reset clears it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_CONV = 1'b1
    } phase_e;

    typedef struct packed {
        logic sel_cur;
        logic sel_prv;
        logic st_cur;
        logic st_prv;
    } pin_hist_t;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det
    import sar_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic start_n,
    output logic sel_low,
    output logic sel_fall,
    output logic start_fall
);

    pin_hist_t hist_d, hist_q;

    always_comb begin
        hist_d         = hist_q;
        hist_d.sel_cur = sel_n;
        hist_d.sel_prv = hist_q.sel_cur;
        hist_d.st_cur  = start_n;
        hist_d.st_prv  = hist_q.st_cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '{sel_cur: 1'b1, sel_prv: 1'b1, st_cur: 1'b1, st_prv: 1'b1};
        end else begin
            hist_q <= hist_d;
        end
    end

    assign sel_low    = ~hist_q.sel_cur;
    assign sel_fall   = hist_q.sel_prv & ~hist_q.sel_cur;
    assign start_fall = hist_q.st_prv & ~hist_q.st_cur;

endmodule

// File: rtl/sar_trim_gate.sv
module sar_trim_gate #(
    parameter int TRIM_CONVS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_evt,
    output logic trim_done
);

    localparam int CW = $clog2(TRIM_CONVS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign trim_done = (cnt_q == CW'(TRIM_CONVS));

    always_comb begin
        cnt_d = cnt_q;
        if (done_evt && !trim_done) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // once the trim window is over it stays over until reset
    assert_trim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trim_done |=> trim_done);

endmodule

// File: rtl/sar_trial_engine.sv
module sar_trial_engine
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic             cmp_bit,
    input  logic             trim_done,
    output logic             busy,
    output logic [WIDTH-1:0] result,
    output logic             valid,
    output logic             done_evt
);

    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    typedef struct packed {
        phase_e           phase;
        logic [IW-1:0]    idx;
        logic [WIDTH-1:0] trial;
        logic [WIDTH-1:0] result;
        logic             valid;
    } eng_t;

    eng_t             eng_d, eng_q;
    logic [WIDTH-1:0] kept_w;
    logic [IW-1:0]    idx_nxt_w;

    always_comb begin
        eng_d       = eng_q;
        eng_d.valid = 1'b0;
        done_evt    = 1'b0;
        kept_w      = eng_q.trial;
        idx_nxt_w   = eng_q.idx - 1'b1;
        if (!cmp_bit) begin
            kept_w[eng_q.idx] = 1'b0;
        end
        case (eng_q.phase)
            PH_IDLE: begin
                if (go) begin
                    eng_d.phase            = PH_CONV;
                    eng_d.idx              = IW'(WIDTH - 1);
                    eng_d.trial            = '0;
                    eng_d.trial[WIDTH - 1] = 1'b1;
                end
            end
            default: begin
                if (abort) begin
                    eng_d.phase  = PH_IDLE;
                    eng_d.idx    = '0;
                    eng_d.trial  = '0;
                    eng_d.result = '0;
                end else if (eng_q.idx == '0) begin
                    eng_d.phase  = PH_IDLE;
                    eng_d.trial  = '0;
                    eng_d.result = kept_w;
                    eng_d.valid  = trim_done;
                    done_evt     = 1'b1;
                end else begin
                    eng_d.trial            = kept_w;
                    eng_d.trial[idx_nxt_w] = 1'b1;
                    eng_d.idx              = idx_nxt_w;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q.phase  <= PH_IDLE;
            eng_q.idx    <= '0;
            eng_q.trial  <= '0;
            eng_q.result <= '0;
            eng_q.valid  <= 1'b0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy   = (eng_q.phase == PH_CONV);
    assign result = eng_q.result;
    assign valid  = eng_q.valid;

    // abort clears everything in one cycle
    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && result == '0 && !valid));

    // data-valid only coincides with the end of a conversion
    assert_valid_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $fell(busy));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int TRIM_CONVS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             start_n,
    input  logic             cmp_bit,
    output logic             busy,
    output logic [WIDTH-1:0] result,
    output logic             result_valid
);

    localparam int RW = $clog2(WIDTH + 1);

    logic sel_low_w, sel_fall_w, start_fall_w;
    logic go_w, abort_w, trim_done_w, done_evt_w;

    sar_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .start_n    (start_n),
        .sel_low    (sel_low_w),
        .sel_fall   (sel_fall_w),
        .start_fall (start_fall_w)
    );

    assign go_w    = !busy && start_fall_w && sel_low_w;
    assign abort_w = busy && ((start_fall_w && sel_low_w) || sel_fall_w);

    sar_trim_gate #(.TRIM_CONVS(TRIM_CONVS)) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_evt  (done_evt_w),
        .trim_done (trim_done_w)
    );

    sar_trial_engine #(.WIDTH(WIDTH)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_w),
        .abort     (abort_w),
        .cmp_bit   (cmp_bit),
        .trim_done (trim_done_w),
        .busy      (busy),
        .result    (result),
        .valid     (result_valid),
        .done_evt  (done_evt_w)
    );

    // length of the current busy run, for the duration check
    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = busy ? run_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_fall_w && sel_low_w));

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort_w)) |-> (run_q == RW'(WIDTH)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go_w) |=> (!busy && $stable(result)));

endmodule

// File: tb/sar_conv_seq_tb_top.sv
`timescale 1ns/1ps
module sar_conv_seq_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sel_n;
    logic         start_n;
    logic         cmp_bit;
    logic         busy;
    logic [W-1:0] result;
    logic         result_valid;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [W-1:0] res;
        logic         vld;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    sar_conv_seq #(.WIDTH(W), .TRIM_CONVS(3)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n        (sel_n),
        .start_n      (start_n),
        .cmp_bit      (cmp_bit),
        .busy         (busy),
        .result       (result),
        .result_valid (result_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // full normal conversion; ign_mid inserts an ignored start edge with select high
    task automatic conv(input logic [W-1:0] pat, input logic exp_v, input bit ign_mid);
        bit all_busy;
        exp_t e;
        e.res = pat;
        e.vld = exp_v;
        sb_q.push_back(e);
        start_n = 1'b0;
        idle_cycles(2);
        chk(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        start_n = 1'b1;
        all_busy = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            if (busy !== 1'b1) all_busy = 1'b0;
            if (ign_mid && i == W / 2) sel_n = 1'b1;
            if (ign_mid && i == W / 2 - 2) start_n = 1'b0;
            if (ign_mid && i == W / 2 - 4) start_n = 1'b1;
            cmp_bit = pat[i];
            @(negedge clk);
        end
        chk(all_busy && busy === 1'b0, ign_mid ? "R4 R11 busy length" : "R4 busy length",
            64'(busy), 64'd0);
        cmp_bit = 1'b0;
        if (ign_mid) begin
            sel_n = 1'b0;
            idle_cycles(2);
            chk(busy === 1'b0 && result === pat, "R5 result held", 64'(result), 64'(pat));
        end
        idle_cycles(2);
    endtask

    // conversion aborted after `step` trials; by_sel picks the select input
    task automatic conv_abort(input int step, input bit by_sel);
        exp_t e;
        e.res = '0;
        e.vld = 1'b0;
        sb_q.push_back(e);
        start_n = 1'b0;
        idle_cycles(2);
        start_n = 1'b1;
        for (int i = 0; i < step; i++) begin
            cmp_bit = 1'b1;
            @(negedge clk);
        end
        if (by_sel) begin
            sel_n = 1'b1;
            idle_cycles(2);
            chk(busy === 1'b1, "R8 select rise ignored", 64'(busy), 64'd1);
            sel_n = 1'b0;
            idle_cycles(2);
            chk(busy === 1'b0 && result === '0 && result_valid === 1'b0, "R8 select abort",
                64'(result), 64'd0);
        end else begin
            start_n = 1'b0;
            idle_cycles(2);
            chk(busy === 1'b0 && result === '0 && result_valid === 1'b0, "R7 start abort",
                64'(result), 64'd0);
            start_n = 1'b1;
        end
        cmp_bit = 1'b0;
        idle_cycles(3);
        chk(busy === 1'b0, "R10 idle after abort", 64'(busy), 64'd0);
    endtask

    // scoreboard monitor
    logic busy_prv = 1'b0;
    logic vld_prv  = 1'b0;
    always @(negedge clk) begin
        exp_t e;
        if (rst_n !== 1'b1) begin
            busy_prv = 1'b0;
            vld_prv  = 1'b0;
        end else begin
            if (busy_prv && !busy) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected completion", 64'(result), 64'd0);
                end else begin
                    e = sb_q.pop_front();
                    chk(result === e.res, "R5 R7 R8 result", 64'(result), 64'(e.res));
                    chk(result_valid === e.vld, "R6 R9 valid", 64'(result_valid), 64'(e.vld));
                end
            end else if (result_valid !== 1'b0) begin
                chk(1'b0, vld_prv ? "R6 valid longer than one cycle" : "R6 stray valid",
                    64'(result_valid), 64'd0);
            end
            busy_prv = busy;
            vld_prv  = result_valid;
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        sel_n   = 1'b0;
        start_n = 1'b1;
        cmp_bit = 1'b0;
        idle_cycles(3);
        chk(busy === 1'b0 && result === '0 && result_valid === 1'b0, "R1 in reset",
            64'(result), 64'd0);
        rst_n = 1'b1;
        idle_cycles(3);
        chk(busy === 1'b0 && result === '0 && result_valid === 1'b0, "R1 after reset",
            64'(result), 64'd0);

        // R3: start edge with select high
        sel_n = 1'b1;
        idle_cycles(2);
        start_n = 1'b0;
        idle_cycles(4);
        chk(busy === 1'b0, "R3 no start when deselected", 64'(busy), 64'd0);
        start_n = 1'b1;
        sel_n = 1'b0;
        idle_cycles(3);
        chk(busy === 1'b0, "R3 select edge while idle", 64'(busy), 64'd0);

        conv(16'hA5A5, 1'b0, 1'b0);   // trim 1
        conv(16'hFFFF, 1'b0, 1'b0);   // trim 2
        conv_abort(5, 1'b0);          // R7, does not count
        conv(16'h0000, 1'b0, 1'b0);   // trim 3 (R9)
        conv(16'h1234, 1'b1, 1'b0);   // first valid (R6)
        conv_abort(12, 1'b1);         // R8
        conv(16'h8001, 1'b1, 1'b1);   // R11
        conv(16'h7FFE, 1'b1, 1'b0);   // R10

        // R9: reset restarts the trim window
        rst_n = 1'b0;
        idle_cycles(2);
        rst_n = 1'b1;
        idle_cycles(3);
        chk(busy === 1'b0 && result === '0, "R1 R9 after second reset", 64'(result), 64'd0);
        conv(16'hC3C3, 1'b0, 1'b0);
        conv(16'h5555, 1'b0, 1'b0);

        idle_cycles(2);
        chk(sb_q.size() == 0, "R5 all results seen", 64'(sb_q.size()), 64'd0);
        finish_run();
    end

endmodule